// File: doc/BRIEF.md
# UART Interrupt Enable, Mask and Status Register Set

This block holds the interrupt control state of a serial port peripheral. Software changes one mask through two write-only ports. A write to the arm port sets mask bits and a write to the disarm port clears them. The mask itself can be read but not written. Event pulses from the receiver, the FIFOs and the receive-timeout counter enter the status register only when their mask bit is set. Status bits stay set until software writes a one to them, so a handler can read the status word and write the same value back to acknowledge everything it saw.

A separate read-only word shows the live FIFO levels (receive trigger, receive empty, transmit empty, transmit full) whatever the mask holds. A single interrupt line is high while any status bit is set and its mask bit is also set. Register data is 13 bits wide. The bus is a plain single-cycle register port and the bits above the valid width read as zero.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset, the mask and status words read 0 and `irq_o` is low.
- R2: A write to the arm port (byte offset 0x00) sets each mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to the disarm port (byte offset 0x04) clears each mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Reads of the arm and disarm ports return 0. A write to the mask word (byte offset 0x08) has no effect on the mask.
- R5: A one-cycle event pulse on `evt_i[k]` sets status bit k only if mask bit k is set. The status bit order is: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing, 7 parity, 8 receive timeout, and 9 to 12 are spare.
- R6: A write to the status word (byte offset 0x0C) clears each status bit whose write-data bit is 1 and leaves bits written as 0 unchanged.
- R7: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq_o` equals the OR over all bits of status AND mask. A status bit that stays set after its mask bit is cleared does not drive `irq_o`.
- R9: Only bits 12:0 are stored. Read data bits 31:13 are always 0, and write-data bits 31:13 are ignored.
- R10: The channel word (byte offset 0x10) shows the live levels in status positions: bit 0 `rx_trig_lvl_i`, bit 1 `rx_empty_lvl_i`, bit 3 `tx_empty_lvl_i`, bit 4 `tx_full_lvl_i`. All other bits are 0 and the mask does not affect it.
- R11: Read data appears on `rdata_o` in the cycle after `rd_en_i`. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| evt_i | input | 13 | One-cycle event pulses, one per status bit |
| rx_trig_lvl_i | input | 1 | Live receive-trigger level |
| rx_empty_lvl_i | input | 1 | Live receive-empty level |
| tx_empty_lvl_i | input | 1 | Live transmit-empty level |
| tx_full_lvl_i | input | 1 | Live transmit-full level |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties assume that an event is a single-cycle pulse. They also assume that a given cycle carries at most one write strobe, aimed at one address. Under those assumptions every mask or status change can be traced to the strobe or pulse in the previous cycle. The stimulus tasks keep to this. Each task raises its strobes or pulses at a falling edge and drops them at the next falling edge. The only cycle that overlaps an event with a write is the one built on purpose to test the collision rule.

// File: rtl/uart_irq_pkg.sv
// Package: shared widths, register selectors and status bit positions for
// the interrupt register set. Assumes a 32-bit register bus.
package uart_irq_pkg;
    localparam int BUS_W = 32;
    localparam int SEL_W = 3;

    // Word selector taken from byte address bits [4:2]
    typedef enum logic [SEL_W-1:0] {
        SEL_ARM    = 3'd0,
        SEL_DISARM = 3'd1,
        SEL_MASK   = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_CHAN   = 3'd4
    } reg_sel_e;

    // Status bit positions (fixed: shared by status, mask and channel words)
    localparam int BIT_RX_TRIG  = 0;
    localparam int BIT_RX_EMPTY = 1;
    localparam int BIT_RX_FULL  = 2;
    localparam int BIT_TX_EMPTY = 3;
    localparam int BIT_TX_FULL  = 4;
    localparam int BIT_OVERRUN  = 5;
    localparam int BIT_FRAMING  = 6;
    localparam int BIT_PARITY   = 7;
    localparam int BIT_TIMEOUT  = 8;
endpackage

// File: rtl/uart_irq_mask_reg.sv
// Module: mask register changed only through set and clear strobes.
// Assumes set_we and clr_we are never high in the same cycle.
module uart_irq_mask_reg #(
    parameter int REG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [REG_W-1:0] wbits,
    output logic [REG_W-1:0] mask_q
);
    // Update the mask: a set strobe ORs bits in, a clear strobe removes them
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (set_we)
            mask_q <= mask_q | wbits;
        else if (clr_we)
            mask_q <= mask_q & ~wbits;
    end

    AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask_q & $past(wbits)) == $past(wbits))); // R2
    AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((mask_q & $past(wbits)) == '0)); // R3
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(mask_q)); // R4
endmodule

// File: rtl/uart_irq_status_reg.sv
// Module: write-one-to-clear status register with one flop per bit.
// Assumes events are single-cycle pulses. A masked event overrides a clear.
module uart_irq_status_reg #(
    parameter int REG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt,
    input  logic [REG_W-1:0] mask,
    input  logic             clr_we,
    input  logic [REG_W-1:0] wbits,
    output logic [REG_W-1:0] stat_q
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;

    // Form per-bit set and clear requests
    always_comb begin
        set_vec = evt & mask;
        clr_vec = clr_we ? wbits : '0;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        // One status flop: set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else if (set_vec[i])
                stat_q[i] <= 1'b1;
            else if (clr_vec[i])
                stat_q[i] <= 1'b0;
        end
    end

    AST_ONLY_MASKED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt & mask)) == '0)); // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(evt & mask)) == $past(evt & mask))); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat_q & $past(wbits) & ~$past(evt & mask)) == '0)); // R6
endmodule

// File: rtl/uart_irq_read_mux.sv
// Module: registered read-data selector. Assumes sel and hit are decoded
// from the same address that accompanies rd_en.
module uart_irq_read_mux
    import uart_irq_pkg::*;
#(
    parameter int REG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             hit,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] mask,
    input  logic [REG_W-1:0] stat,
    input  logic [REG_W-1:0] chan,
    output logic [BUS_W-1:0] rdata
);
    localparam int PAD_W = BUS_W - REG_W;

    logic [REG_W-1:0] pick;

    // Choose the word addressed by the current read
    always_comb begin
        pick = '0;
        if (hit) begin
            case (sel)
                SEL_MASK: pick = mask;
                SEL_STAT: pick = stat;
                SEL_CHAN: pick = chan;
                default:  pick = '0;
            endcase
        end
    end

    // Capture read data one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= {{PAD_W{1'b0}}, pick};
    end

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit && (sel == SEL_ARM || sel == SEL_DISARM)) |=> (rdata == '0)); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BUS_W-1:REG_W] == '0); // R9
endmodule

// File: rtl/uart_irq_regs.sv
// Module: top of the interrupt register set. Decodes the bus and wires the
// mask, status and read paths, and drives the interrupt line.
// Assumes one access per cycle and ADDR_W greater than 5.
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic [REG_W-1:0]  evt_i,
    input  logic              rx_trig_lvl_i,
    input  logic              rx_empty_lvl_i,
    input  logic              tx_empty_lvl_i,
    input  logic              tx_full_lvl_i,
    output logic              irq_o
);
    localparam int HI_LSB = SEL_W + 2;

    logic             hit;
    reg_sel_e         sel;
    logic             arm_we, disarm_we, stat_we;
    logic [REG_W-1:0] wbits;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] chan;

    // Decode the byte address into a word selector and write strobes
    always_comb begin
        hit       = (addr_i[ADDR_W-1:HI_LSB] == '0);
        sel       = reg_sel_e'(addr_i[HI_LSB-1:2]);
        arm_we    = wr_en_i && hit && (sel == SEL_ARM);
        disarm_we = wr_en_i && hit && (sel == SEL_DISARM);
        stat_we   = wr_en_i && hit && (sel == SEL_STAT);
        wbits     = wdata_i[REG_W-1:0];
    end

    // Place the live FIFO levels at their status bit positions
    always_comb begin
        chan               = '0;
        chan[BIT_RX_TRIG]  = rx_trig_lvl_i;
        chan[BIT_RX_EMPTY] = rx_empty_lvl_i;
        chan[BIT_TX_EMPTY] = tx_empty_lvl_i;
        chan[BIT_TX_FULL]  = tx_full_lvl_i;
    end

    uart_irq_mask_reg #(.REG_W(REG_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (arm_we),
        .clr_we (disarm_we),
        .wbits  (wbits),
        .mask_q (mask_q)
    );

    uart_irq_status_reg #(.REG_W(REG_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_i),
        .mask   (mask_q),
        .clr_we (stat_we),
        .wbits  (wbits),
        .stat_q (stat_q)
    );

    uart_irq_read_mux #(.REG_W(REG_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en_i),
        .hit   (hit),
        .sel   (sel),
        .mask  (mask_q),
        .stat  (stat_q),
        .chan  (chan),
        .rdata (rdata_o)
    );

    // Raise the interrupt while any enabled status bit is pending
    always_comb irq_o = |(stat_q & mask_q);

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_we && (wbits == {REG_W{1'b1}}) |=> !irq_o); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && rdata_o == '0)); // R1
endmodule

// File: tb/uart_irq_regs_tb.sv
`timescale 1ns/1ps
module uart_irq_regs_tb;
    localparam logic [7:0] A_ARM = 8'h00, A_DIS = 8'h04, A_MASK = 8'h08,
                           A_STAT = 8'h0C, A_CHAN = 8'h10, A_NONE = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [12:0] evt = '0;
    logic        rx_trig = 1'b0, rx_empty = 1'b0, tx_empty = 1'b0, tx_full = 1'b0;
    logic        irq;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    uart_irq_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
        .rx_trig_lvl_i(rx_trig), .rx_empty_lvl_i(rx_empty),
        .tx_empty_lvl_i(tx_empty), .tx_full_lvl_i(tx_full), .irq_o(irq)
    );

    // Monitor: note each read strobe, compare its data at the next falling edge
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected read data %h", "R11", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: read %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    // Driver: push the expected value, then issue the read
    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [12:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        tests++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run incomplete expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rx_empty = 1'b1; tx_empty = 1'b1;
        // R1 reset state
        bus_rd(A_MASK, 32'h0, "R1");
        bus_rd(A_STAT, 32'h0, "R1");
        chk_irq(1'b0, "R1");
        // R10 live levels with empty mask
        bus_rd(A_CHAN, 32'h0000_000A, "R10");
        // R2 set and no-effect zeros
        bus_wr(A_ARM, 32'h0000_0105);
        bus_rd(A_MASK, 32'h105, "R2");
        bus_wr(A_ARM, 32'h0);
        bus_rd(A_MASK, 32'h105, "R2");
        // R4 write-only ports read zero; mask word not writable
        bus_rd(A_ARM, 32'h0, "R4");
        bus_rd(A_DIS, 32'h0, "R4");
        bus_wr(A_MASK, 32'h0000_FFFF);
        bus_rd(A_MASK, 32'h105, "R4");
        // R9 upper bits dropped
        bus_wr(A_ARM, 32'hFFFF_FFFF);
        bus_rd(A_MASK, 32'h1FFF, "R9");
        // R3 clear
        bus_wr(A_DIS, 32'hFFFF_FFFF);
        bus_rd(A_MASK, 32'h0, "R3");
        bus_wr(A_ARM, 32'h105);
        bus_wr(A_DIS, 32'h004);
        bus_rd(A_MASK, 32'h101, "R3");
        // R5 only masked events latch
        pulse(13'h1FFF);
        bus_rd(A_STAT, 32'h101, "R5");
        chk_irq(1'b1, "R8");
        // R6 write-one-to-clear
        bus_wr(A_STAT, 32'h001);
        bus_rd(A_STAT, 32'h100, "R6");
        bus_wr(A_STAT, 32'h0);
        bus_rd(A_STAT, 32'h100, "R6");
        // R8 irq gated by mask while status stays pending
        bus_wr(A_DIS, 32'h100);
        bus_rd(A_STAT, 32'h100, "R8");
        chk_irq(1'b0, "R8");
        bus_wr(A_ARM, 32'h100);
        chk_irq(1'b1, "R8");
        bus_wr(A_STAT, 32'h100);
        chk_irq(1'b0, "R6");
        // R7 event and clear in the same cycle
        @(negedge clk);
        evt = 13'h001; wr_en = 1'b1; addr = A_STAT; wdata = 32'h001;
        @(negedge clk);
        evt = '0; wr_en = 1'b0; wdata = '0;
        bus_rd(A_STAT, 32'h001, "R7");
        chk_irq(1'b1, "R7");
        bus_wr(A_STAT, 32'h001);
        // R10 levels change, mask does not matter
        rx_trig = 1'b1; tx_full = 1'b1; rx_empty = 1'b0; tx_empty = 1'b0;
        bus_wr(A_DIS, 32'h1FFF);
        bus_rd(A_CHAN, 32'h0000_0011, "R10");
        // R11 unmapped offset
        bus_rd(A_NONE, 32'h0, "R11");
        bus_rd(8'h40, 32'h0, "R11");
        repeat (4) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R11: %0d reads unanswered expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule